// File: doc/BRIEF.md
# Period-Measurement Timer Counter

This block is the 16-bit up-counter of a duty and period measurement timer channel. It counts one of seven prescaled internal count enables or the edges of an external clock. A 3-bit select field in the control register picks the source. In timer mode the counter runs while the start bit is set. Software may load it with a full 16-bit word, and clearing the start bit returns it to zero.

In cycle measurement mode the counter restarts from zero on each chosen edge of the measured input, so the value reached just before a restart is the input period in count units. Software loads are locked out in this mode. Both asynchronous inputs pass through a two-flop synchronizer and an edge detector. A sticky overflow flag records every wrap from 0xFFFF to 0x0000.

Register map (word address, `bus_addr`): 0 is the counter, 1 is the control register, 2 is the status register, and 3 reads as zero. Control bits: [2:0] source select, [3] external clock falling edge (0 selects rising), [4] measured input falling edge (0 selects rising), [5] mode (0 timer, 1 cycle measurement), [6] start. Status bit [0] is the overflow flag.

Top module: `pmt_timer_counter`

## Requirements
- R1: After reset the counter reads 0x0000, the overflow flag is 0 and the control register is 0x00.
- R2: Select codes 3'b000 to 3'b110 advance the started counter once every 1, 2, 4, 8, 16, 32 and 64 clock cycles in that order, so 64 consecutive started cycles add 64, 32, 16, 8, 4, 2 and 1.
- R3: Select code 3'b111 advances the counter on each external clock edge of the kind chosen by control bit 3 (0 rising, 1 falling). An input change takes effect at the third rising clock edge after it.
- R4: A counter wrap from 0xFFFF to 0x0000 sets the overflow flag, which stays set until a write to address 2 with byte enable 0 set and data bit 0 equal to 0 clears it. A wrap in the same cycle as such a clear leaves the flag at 1.
- R5: In timer mode the counter advances only while start is 1. A control write that changes start from 1 to 0 sets the counter to 0x0000.
- R6: In timer mode a write to address 0 with both byte enables set loads the counter, whether it is stopped or running. In a cycle where a count enable also occurs, the written value wins.
- R7: In cycle measurement mode with start set, the measured-input edge chosen by control bit 4 (0 rising, 1 falling) clears the counter at the third rising clock edge after the input change. The other edge has no effect.
- R8: In cycle measurement mode, writes to address 0 leave the counter unchanged.
- R9: A write to address 0 with only one byte enable set leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| meas_in | input | 1 | Asynchronous measured waveform |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address for writes and reads |
| bus_be | input | 2 | Byte enables, bit 0 low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| cnt_o | output | 16 | Current counter value |
| ovf_o | output | 1 | Overflow flag |

## Verification
Every cycle, the assertions check these properties: a timer-mode word load lands exactly, and a cycle-mode load or a partial-byte load does not disturb a counter that is not otherwise moving. A stop clears the counter and a selected measured edge clears it. A wrap sets the flag and the flag is sticky. The synchronized edges are single-cycle pulses, and the divide-by-2 enable alternates. Some results can only be seen from the bench's scenarios: the exact count that each divider yields over a 64-cycle window, the three-edge latency of the input paths, which edge each polarity setting selects, and the set-over-clear race on the overflow flag.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
    localparam int CNT_W = 16;
    localparam int N_DIV = 7;
    localparam int SEL_W = $clog2(N_DIV + 1);

    typedef enum logic {
        MODE_TIMER = 1'b0,
        MODE_CYCLE = 1'b1
    } mode_e;

    typedef struct packed {
        logic             start;
        mode_e            mode;
        logic             meas_fall;
        logic             ext_fall;
        logic [SEL_W-1:0] clk_sel;
    } ctrl_t;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
    parameter int N_DIV = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [N_DIV-1:0] div_tick
);
    localparam int PRE_W = (N_DIV > 1) ? N_DIV - 1 : 1;

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // divide by 2**k: pulse when the low k prescaler bits are all ones
    for (genvar k = 0; k < N_DIV; k++) begin : g_tick
        if (k == 0) begin : g_div1
            assign div_tick[k] = 1'b1;
        end else begin : g_divn
            assign div_tick[k] = &pre_q[k-1:0];
        end
    end

    if (N_DIV > 1) begin : g_chk
        p_div2_alternates_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            div_tick[1] |=> !div_tick[1]);
    end
endmodule

// File: rtl/pmt_edge_sync.sv
module pmt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } es_t;

    es_t es_d, es_q;

    always_comb begin
        es_d      = es_q;
        es_d.sync = {es_q.sync[0], async_in};
        es_d.prev = es_q.sync[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end

    assign rise = es_q.sync[1] & ~es_q.prev;
    assign fall = ~es_q.sync[1] & es_q.prev;

    p_edge_exclusive_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
    p_rise_one_cycle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pmt_count_core.sv
module pmt_count_core
    import pmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_e        mode,
    input  logic         start,
    input  logic         tick,
    input  logic         meas_edge,
    input  logic         stop_clr,
    input  logic         wr_full,
    input  logic         ovf_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } core_t;

    core_t st_d, st_q;
    logic  wrap;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (mode == MODE_TIMER) begin
            if (wr_full) begin
                st_d.cnt = wdata;
            end else if (stop_clr) begin
                st_d.cnt = '0;
            end else if (start && tick) begin
                st_d.cnt = st_q.cnt + 1'b1;
                wrap     = &st_q.cnt;
            end
        end else begin
            if (start && meas_edge) begin
                st_d.cnt = '0;
            end else if (start && tick) begin
                st_d.cnt = st_q.cnt + 1'b1;
                wrap     = &st_q.cnt;
            end
        end
        if (ovf_clr) st_d.ovf = 1'b0;
        if (wrap)    st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    p_timer_load_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TIMER && wr_full) |=> cnt == $past(wdata));
    p_cycle_locked_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CYCLE && wr_full && !tick && !meas_edge) |=> $stable(cnt));
    p_stop_clears_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TIMER && stop_clr && !wr_full) |=> cnt == '0);
    p_meas_clears_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CYCLE && start && meas_edge) |=> cnt == '0);
    p_wrap_sets_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (start && tick && (&cnt) && !stop_clr && !meas_edge && !wr_full) |=> ovf);
    p_ovf_sticky_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/pmt_timer_counter.sv
module pmt_timer_counter
    import pmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_clk_in,
    input  logic        meas_in,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [15:0] cnt_o,
    output logic        ovf_o
);
    localparam int SRC_N  = N_DIV + 1;
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t ctrl;
    } top_t;

    top_t             top_d, top_q;
    logic [N_DIV-1:0] div_tick;
    logic [SRC_N-1:0] src_vec;
    logic             ext_rise, ext_fall, meas_rise, meas_fall;
    logic             ext_tick, meas_edge, tick;
    logic             wr_ctrl, wr_full, stop_clr, ovf_clr;
    ctrl_t            ctrl_new;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL) && bus_be[0];
    assign wr_full  = bus_wr && (bus_addr == ADDR_CNT) && (bus_be == 2'b11);
    assign ovf_clr  = bus_wr && (bus_addr == ADDR_STAT) && bus_be[0] && !bus_wdata[0];
    assign ctrl_new = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign stop_clr = wr_ctrl && !ctrl_new.start && top_q.ctrl.start
                      && (top_q.ctrl.mode == MODE_TIMER);

    always_comb begin
        top_d = top_q;
        if (wr_ctrl) top_d.ctrl = ctrl_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    pmt_prescaler #(.N_DIV(N_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_tick (div_tick)
    );

    pmt_edge_sync u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    pmt_edge_sync u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (meas_in),
        .rise     (meas_rise),
        .fall     (meas_fall)
    );

    assign ext_tick  = top_q.ctrl.ext_fall  ? ext_fall  : ext_rise;
    assign meas_edge = top_q.ctrl.meas_fall ? meas_fall : meas_rise;
    assign src_vec   = {ext_tick, div_tick};
    assign tick      = src_vec[top_q.ctrl.clk_sel];

    pmt_count_core #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (top_q.ctrl.mode),
        .start     (top_q.ctrl.start),
        .tick      (tick),
        .meas_edge (meas_edge),
        .stop_clr  (stop_clr),
        .wr_full   (wr_full),
        .ovf_clr   (ovf_clr),
        .wdata     (bus_wdata),
        .cnt       (cnt_o),
        .ovf       (ovf_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CNT:  bus_rdata = cnt_o;
            ADDR_CTRL: bus_rdata[CTRL_W-1:0] = top_q.ctrl;
            ADDR_STAT: bus_rdata[0] = ovf_o;
            default:   bus_rdata = '0;
        endcase
    end

    p_partial_ignored_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CNT && bus_be != 2'b11 && !top_q.ctrl.start)
        |=> $stable(cnt_o));
endmodule

// File: tb/pmt_timer_counter_test.sv
module pmt_timer_counter_test;
    localparam time CLK_PERIOD = 10ns;

    // {select code, expected increments over 64 started cycles}
    localparam logic [18:0] DIV_VEC [7] = '{
        {3'd0, 16'd64}, {3'd1, 16'd32}, {3'd2, 16'd16}, {3'd3, 16'd8},
        {3'd4, 16'd4},  {3'd5, 16'd2},  {3'd6, 16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_in = 1'b0;
    logic        meas_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [1:0]  bus_be = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [15:0] cnt_o;
    logic        ovf_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmt_timer_counter uut (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .meas_in(meas_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_o(cnt_o), .ovf_o(ovf_o)
    );

    function automatic logic [15:0] ctl(input logic [2:0] sel, input logic extf,
                                        input logic measf, input logic cyc, input logic st);
        return {9'd0, st, cyc, measf, extf, sel};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cnt", cnt_o, 16'h0000);
        chk("R1 ovf", {15'd0, ovf_o}, 16'h0000);
        bus_addr = 2'd1; #1;
        chk("R1 ctrl", bus_rdata, 16'h0000);

        // R2 divider table
        for (int i = 0; i < 7; i++) begin
            wr(2'd1, 2'b01, ctl(DIV_VEC[i][18:16], 1'b0, 1'b0, 1'b0, 1'b0));
            wr(2'd0, 2'b11, 16'h0000);
            wr(2'd1, 2'b01, ctl(DIV_VEC[i][18:16], 1'b0, 1'b0, 1'b0, 1'b1));
            cycles(64);
            chk("R2 divider count", cnt_o, DIV_VEC[i][15:0]);
        end

        // R6 load while running wins over count; R4 wrap and flag
        wr(2'd1, 2'b01, ctl(3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(2'd0, 2'b11, 16'hFFFF);
        chk("R6 load over tick", cnt_o, 16'hFFFF);
        cycles(1);
        chk("R4 wrap value", cnt_o, 16'h0000);
        chk("R4 ovf set", {15'd0, ovf_o}, 16'h0001);
        cycles(3);
        chk("R4 ovf sticky", {15'd0, ovf_o}, 16'h0001);
        wr(2'd2, 2'b01, 16'h0000);
        chk("R4 ovf cleared", {15'd0, ovf_o}, 16'h0000);
        wr(2'd0, 2'b11, 16'hFFFF);
        wr(2'd2, 2'b01, 16'h0000);
        chk("R4 set beats clear", {15'd0, ovf_o}, 16'h0001);

        // R5 stop clears and holds
        wr(2'd1, 2'b01, ctl(3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        chk("R5 stop clears", cnt_o, 16'h0000);
        cycles(5);
        chk("R5 stopped holds", cnt_o, 16'h0000);

        // R9 partial writes ignored, R6 stopped load
        wr(2'd0, 2'b01, 16'h1234);
        chk("R9 low byte ignored", cnt_o, 16'h0000);
        wr(2'd0, 2'b10, 16'h1234);
        chk("R9 high byte ignored", cnt_o, 16'h0000);
        wr(2'd0, 2'b11, 16'h00AB);
        chk("R6 stopped load", cnt_o, 16'h00AB);

        // R8 cycle mode write lock (stopped)
        wr(2'd1, 2'b01, ctl(3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        wr(2'd0, 2'b11, 16'h5555);
        chk("R8 write ignored", cnt_o, 16'h00AB);

        // R7 measurement, rising edge selected
        wr(2'd1, 2'b01, ctl(3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        meas_in = 1'b1;
        cycles(3);
        chk("R7 rising clears", cnt_o, 16'h0000);
        cycles(10);
        chk("R7 period count", cnt_o, 16'd10);
        meas_in = 1'b0;
        cycles(6);
        chk("R7 falling ignored", cnt_o, 16'd16);
        wr(2'd0, 2'b11, 16'h0000);
        chk("R8 running write ignored", cnt_o, 16'd17);
        wr(2'd1, 2'b01, ctl(3'd0, 1'b0, 1'b1, 1'b1, 1'b1));
        meas_in = 1'b1;
        cycles(3);
        chk("R7 rising ignored when falling set", cnt_o, 16'd21);
        meas_in = 1'b0;
        cycles(3);
        chk("R7 falling clears", cnt_o, 16'h0000);

        // R3 external clock, rising then falling
        wr(2'd1, 2'b01, ctl(3'd7, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(2'd0, 2'b11, 16'h0000);
        wr(2'd1, 2'b01, ctl(3'd7, 1'b0, 1'b0, 1'b0, 1'b1));
        for (int i = 0; i < 5; i++) begin
            ext_clk_in = 1'b1; cycles(4);
            ext_clk_in = 1'b0; cycles(4);
        end
        chk("R3 rising edges", cnt_o, 16'd5);
        ext_clk_in = 1'b1;
        cycles(2);
        chk("R3 latency two edges", cnt_o, 16'd5);
        cycles(1);
        chk("R3 latency third edge", cnt_o, 16'd6);
        ext_clk_in = 1'b0;
        cycles(4);
        wr(2'd1, 2'b01, ctl(3'd7, 1'b1, 1'b0, 1'b0, 1'b0));
        chk("R5 stop clears ext", cnt_o, 16'h0000);
        wr(2'd1, 2'b01, ctl(3'd7, 1'b1, 1'b0, 1'b0, 1'b1));
        for (int i = 0; i < 3; i++) begin
            ext_clk_in = 1'b1; cycles(4);
            ext_clk_in = 1'b0; cycles(4);
        end
        chk("R3 falling edges", cnt_o, 16'd3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule